// File: doc/BRIEF.md
# Stride Reference Prediction Table

This block records, for each load/store instruction, the last operand address it touched and the stride between its successive operand addresses. It then predicts the next operand address of that instruction. It is a direct-mapped table indexed by the instruction address. Each entry carries a valid bit, a tag, the previous operand address, a signed stride and a two-bit confidence state.

There are two ports. The update port is driven when an instruction actually executes, and carries its PC and effective operand address. On that port the table allocates entries and walks each entry through a four-state confidence machine. The lookup port is driven by a look-ahead PC. It answers in the same cycle with a predicted address and a valid flag, so that a later stage can decide whether to issue a preload. That stage, and any cache presence check, lie outside this block.

Top module: `stride_pred_table`

## Requirements
- R1: After reset every entry is empty, so every lookup returns look_valid = 0 until the matching PC has been written through the update port.
- R2: An update whose PC is not present allocates the entry. A present entry counts only if it is valid and its tag equals the PC's upper bits; a valid entry holding another tag is replaced. Allocation sets the previous address to the operand address, the stride to 0 and the state to initial, so the next lookup predicts that same address.
- R3: An update is correct when its address equals previous address plus stride. A correct update in initial, transient or steady moves the entry to steady, keeps the stride and stores the new address.
- R4: An incorrect update in initial stores stride = new address minus previous address, stores the new address, and moves the entry to transient.
- R5: An incorrect update in steady stores the new address, keeps the old stride unchanged, and moves the entry to initial.
- R6: An incorrect update in transient stores the new stride and address and moves the entry to no-prediction. An incorrect update in no-prediction stores the new stride and address and stays there.
- R7: A correct update in no-prediction stores the address, keeps the stride and moves the entry to transient, so predictions resume.
- R8: A lookup that misses, or that hits an entry in no-prediction, returns look_valid = 0. Otherwise it returns look_valid = 1 and look_addr = previous address plus stride, combinationally in the same cycle.
- R9: When an update and a lookup address the same entry in one cycle, the lookup returns the contents from before that update.
- R10: The stride is a two's-complement value as wide as the address. Negative strides work, and the predicted address wraps modulo 2^ADDR_W.
- R11: The entry index is PC bits [9:2] (PC_LSB = 2, IDX_W = 8, 256 entries) and the tag is all higher PC bits. PC bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears all valid bits |
| upd_en | input | 1 | Executed load/store reported this cycle |
| upd_pc | input | PC_W | Address of the executed instruction |
| upd_addr | input | ADDR_W | Effective operand address of that instruction |
| look_pc | input | PC_W | Look-ahead PC to predict for |
| look_valid | output | 1 | Prediction available for look_pc |
| look_addr | output | ADDR_W | Predicted operand address |

## Verification
The no-prediction state is the hardest condition to reach. An entry only gets there after two consecutive wrong strides, and it can only be seen from the ports by a lookup that is silent while the entry still exists. The stimulus trains an entry to steady, breaks it twice with irregular addresses, and confirms the silence. It then feeds an irregular address again, followed by one that matches the newly learned stride, to show that the entry stays suppressed and then recovers. A second PC that shares the index but not the tag is used to show replacement, and an address pair that crosses zero shows wrapping.

// File: rtl/srpt_pkg.sv
package srpt_pkg;
   // Confidence state per entry; the encoding is only used inside the table.
   typedef enum logic [1:0] {
      ST_INIT   = 2'd0,
      ST_TRANS  = 2'd1,
      ST_STEADY = 2'd2,
      ST_NOPRED = 2'd3
   } conf_t;
endpackage

// File: rtl/srpt_split.sv
// Splits an instruction address into table index and tag.
module srpt_split #(
   parameter int PC_W   = 32,
   parameter int IDX_W  = 8,
   parameter int PC_LSB = 2,
   localparam int TAG_W = PC_W - IDX_W - PC_LSB
) (
   input  logic [PC_W-1:0]  pc,
   output logic [IDX_W-1:0] idx,
   output logic [TAG_W-1:0] tag
);
   assign idx = pc[PC_LSB +: IDX_W];
   assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/srpt_next.sv
// Next-entry computation for one executed load/store.
module srpt_next
   import srpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              hit,
   input  conf_t             cur_state,
   input  logic [ADDR_W-1:0] cur_prev,
   input  logic [ADDR_W-1:0] cur_stride,
   input  logic [ADDR_W-1:0] addr,
   output logic              correct,
   output conf_t             nxt_state,
   output logic [ADDR_W-1:0] nxt_prev,
   output logic [ADDR_W-1:0] nxt_stride
);
   logic [ADDR_W-1:0] expect_addr;
   logic [ADDR_W-1:0] delta;

   assign expect_addr = cur_prev + cur_stride;
   assign delta       = addr - cur_prev;
   assign correct     = (addr == expect_addr);
   assign nxt_prev    = addr;

   always_comb begin
      nxt_state  = cur_state;
      nxt_stride = cur_stride;
      if (!hit) begin
         nxt_state  = ST_INIT;
         nxt_stride = '0;
      end else begin
         unique case (cur_state)
            ST_INIT: begin
               if (correct) nxt_state = ST_STEADY;
               else begin
                  nxt_state  = ST_TRANS;
                  nxt_stride = delta;
               end
            end
            ST_TRANS: begin
               if (correct) nxt_state = ST_STEADY;
               else begin
                  nxt_state  = ST_NOPRED;
                  nxt_stride = delta;
               end
            end
            ST_STEADY: begin
               if (!correct) nxt_state = ST_INIT;
            end
            ST_NOPRED: begin
               if (correct) nxt_state = ST_TRANS;
               else         nxt_stride = delta;
            end
            default: nxt_state = ST_INIT;
         endcase
      end
   end
endmodule

// File: rtl/srpt_predict.sv
// Lookup answer from the addressed entry.
module srpt_predict
   import srpt_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              hit,
   input  conf_t             state,
   input  logic [ADDR_W-1:0] prev,
   input  logic [ADDR_W-1:0] stride,
   output logic              valid,
   output logic [ADDR_W-1:0] pred
);
   assign valid = hit && (state != ST_NOPRED);
   assign pred  = prev + stride;
endmodule

// File: rtl/stride_pred_table.sv
module stride_pred_table
   import srpt_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 8,
   parameter int PC_LSB = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic [ADDR_W-1:0] upd_addr,
   input  logic [PC_W-1:0]   look_pc,
   output logic              look_valid,
   output logic [ADDR_W-1:0] look_addr
);
   localparam int ENTRIES = 1 << IDX_W;
   localparam int TAG_W   = PC_W - IDX_W - PC_LSB;

   if (TAG_W < 1) begin : g_bad_split
      $error("stride_pred_table: PC_W too small for IDX_W + PC_LSB");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("stride_pred_table: ADDR_W must be at least 2");
   end

   logic              vld_q    [ENTRIES];
   logic [TAG_W-1:0]  tag_q    [ENTRIES];
   logic [ADDR_W-1:0] prev_q   [ENTRIES];
   logic [ADDR_W-1:0] stride_q [ENTRIES];
   conf_t             st_q     [ENTRIES];

   // Update side
   logic [IDX_W-1:0]  upd_idx;
   logic [TAG_W-1:0]  upd_tag;
   logic              upd_hit;
   logic              upd_correct;
   conf_t             upd_state;
   logic [ADDR_W-1:0] upd_prev;
   logic [ADDR_W-1:0] upd_stride;
   conf_t             new_state;
   logic [ADDR_W-1:0] new_prev;
   logic [ADDR_W-1:0] new_stride;

   srpt_split #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_upd_split (
      .pc (upd_pc),
      .idx(upd_idx),
      .tag(upd_tag)
   );

   assign upd_hit    = vld_q[upd_idx] && (tag_q[upd_idx] == upd_tag);
   assign upd_state  = st_q[upd_idx];
   assign upd_prev   = prev_q[upd_idx];
   assign upd_stride = stride_q[upd_idx];

   srpt_next #(.ADDR_W(ADDR_W)) u_next (
      .hit       (upd_hit),
      .cur_state (upd_state),
      .cur_prev  (upd_prev),
      .cur_stride(upd_stride),
      .addr      (upd_addr),
      .correct   (upd_correct),
      .nxt_state (new_state),
      .nxt_prev  (new_prev),
      .nxt_stride(new_stride)
   );

   // Storage: one slice per entry; only the valid bit is reset.
   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic wr;
      assign wr = upd_en && (upd_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  vld_q[e] <= 1'b0;
         else if (wr) vld_q[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (wr) begin
            tag_q[e]    <= upd_tag;
            prev_q[e]   <= new_prev;
            stride_q[e] <= new_stride;
            st_q[e]     <= new_state;
         end
      end
   end

   // Lookup side: reads the registered entries, so a same-cycle update
   // is not yet visible.
   logic [IDX_W-1:0] look_idx;
   logic [TAG_W-1:0] look_tag;
   logic             look_hit;

   srpt_split #(.PC_W(PC_W), .IDX_W(IDX_W), .PC_LSB(PC_LSB)) u_look_split (
      .pc (look_pc),
      .idx(look_idx),
      .tag(look_tag)
   );

   assign look_hit = vld_q[look_idx] && (tag_q[look_idx] == look_tag);

   srpt_predict #(.ADDR_W(ADDR_W)) u_predict (
      .hit   (look_hit),
      .state (st_q[look_idx]),
      .prev  (prev_q[look_idx]),
      .stride(stride_q[look_idx]),
      .valid (look_valid),
      .pred  (look_addr)
   );
endmodule

// File: rtl/srpt_checker.sv
module srpt_checker
   import srpt_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              upd_en,
   input logic [PC_W-1:0]   upd_pc,
   input logic [ADDR_W-1:0] upd_addr,
   input logic [PC_W-1:0]   look_pc,
   input logic              look_valid,
   input logic [ADDR_W-1:0] look_addr,
   input logic              upd_hit,
   input logic              upd_correct,
   input conf_t             upd_state,
   input logic [ADDR_W-1:0] upd_prev,
   input logic [ADDR_W-1:0] upd_stride
);
   // R1: first cycle out of reset sees an empty table
   a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !look_valid)
      else $error("a_r1_empty_after_reset");

   // R2: a freshly allocated entry predicts the address just written
   a_r2_alloc_predicts_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_hit) |=>
         ((look_pc == $past(upd_pc)) -> (look_valid && look_addr == $past(upd_addr))))
      else $error("a_r2_alloc_predicts_addr");

   // R3: a correct update in a predicting state continues the same stride
   a_r3_correct_keeps_step: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_hit && upd_correct && upd_state != ST_NOPRED) |=>
         ((look_pc == $past(upd_pc)) ->
            (look_valid && look_addr == $past(upd_addr) + ($past(upd_addr) - $past(upd_prev)))))
      else $error("a_r3_correct_keeps_step");

   // R5: a miss in steady keeps the old stride
   a_r5_steady_miss_keeps_stride: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_hit && !upd_correct && upd_state == ST_STEADY) |=>
         ((look_pc == $past(upd_pc)) ->
            (look_valid && look_addr == $past(upd_addr) + $past(upd_stride))))
      else $error("a_r5_steady_miss_keeps_stride");

   // R6: a miss in transient silences the entry
   a_r6_transient_miss_mutes: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_hit && !upd_correct && upd_state == ST_TRANS) |=>
         ((look_pc == $past(upd_pc)) -> !look_valid))
      else $error("a_r6_transient_miss_mutes");

   // R7: a correct update in no-prediction re-enables predictions
   a_r7_recover_from_nopred: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_hit && upd_correct && upd_state == ST_NOPRED) |=>
         ((look_pc == $past(upd_pc)) -> look_valid))
      else $error("a_r7_recover_from_nopred");
endmodule

bind stride_pred_table srpt_checker #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_srpt_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_en     (upd_en),
   .upd_pc     (upd_pc),
   .upd_addr   (upd_addr),
   .look_pc    (look_pc),
   .look_valid (look_valid),
   .look_addr  (look_addr),
   .upd_hit    (upd_hit),
   .upd_correct(upd_correct),
   .upd_state  (upd_state),
   .upd_prev   (upd_prev),
   .upd_stride (upd_stride)
);

// File: tb/stride_pred_table_bench.sv
module stride_pred_table_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [31:0] upd_pc = '0;
   logic [31:0] upd_addr = '0;
   logic [31:0] look_pc = '0;
   logic        look_valid;
   logic [31:0] look_addr;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   stride_pred_table u_stride_pred_table (
      .clk(clk), .rst_n(rst_n),
      .upd_en(upd_en), .upd_pc(upd_pc), .upd_addr(upd_addr),
      .look_pc(look_pc), .look_valid(look_valid), .look_addr(look_addr)
   );

   typedef struct packed {
      logic        ue;
      logic [31:0] upc;
      logic [31:0] uad;
      logic [31:0] lpc;
      logic        ev;
      logic [31:0] ea;
      logic [7:0]  rq;
   } vec_t;

   localparam logic [31:0] P = 32'h100;  // index 0x40
   localparam logic [31:0] Q = 32'h500;  // index 0x40, other tag
   localparam logic [31:0] R = 32'h104;  // index 0x41
   localparam logic [31:0] S = 32'h200;  // index 0x80
   localparam int NV = 29;

   // Lookup in each row sees the table before that row's update.
   localparam vec_t VEC [NV] = '{
      '{1'b1, P, 32'h1000,     P,          1'b0, 32'h0,        8'd1 },  // R1 empty
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h1000,     8'd2 },  // R2 alloc
      '{1'b1, P, 32'h1010,     P,          1'b1, 32'h1000,     8'd9 },  // R9 pre-update
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h1020,     8'd4 },  // R4 learned +0x10
      '{1'b1, P, 32'h1020,     P,          1'b1, 32'h1020,     8'd9 },  // to steady
      '{1'b1, P, 32'h1030,     P,          1'b1, 32'h1030,     8'd3 },  // R3 steady
      '{1'b1, P, 32'h1100,     P,          1'b1, 32'h1040,     8'd3 },  // steady miss
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h1110,     8'd5 },  // R5 stride kept
      '{1'b1, P, 32'h1110,     P,          1'b1, 32'h1110,     8'd5 },  // init -> steady
      '{1'b1, P, 32'h1000,     P,          1'b1, 32'h1120,     8'd3 },  // steady miss
      '{1'b1, P, 32'h0FF0,     P,          1'b1, 32'h1010,     8'd5 },  // init miss, -0x10
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h0FE0,     8'd10},  // R10 negative
      '{1'b1, P, 32'h0FF0,     P,          1'b1, 32'h0FE0,     8'd4 },  // transient miss
      '{1'b0, P, 32'h0,        P,          1'b0, 32'h0,        8'd6 },  // R6 silenced
      '{1'b1, P, 32'h0FF0,     P,          1'b0, 32'h0,        8'd8 },  // R8 nopred correct
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h0FF0,     8'd7 },  // R7 resumed
      '{1'b1, P, 32'h0FF8,     P,          1'b1, 32'h0FF0,     8'd6 },  // transient miss
      '{1'b1, P, 32'h1200,     P,          1'b0, 32'h0,        8'd6 },  // nopred miss
      '{1'b1, P, 32'h1408,     P,          1'b0, 32'h0,        8'd7 },  // still nopred
      '{1'b0, P, 32'h0,        P,          1'b1, 32'h1610,     8'd7 },  // stride 0x208
      '{1'b0, P, 32'h0,        Q,          1'b0, 32'h0,        8'd11},  // R11 tag differs
      '{1'b1, Q, 32'h5000,     P,          1'b1, 32'h1610,     8'd9 },  // Q replaces P
      '{1'b0, P, 32'h0,        P,          1'b0, 32'h0,        8'd2 },  // P gone
      '{1'b0, P, 32'h0,        Q,          1'b1, 32'h5000,     8'd2 },  // Q present
      '{1'b0, P, 32'h0,        Q | 32'h2,  1'b1, 32'h5000,     8'd11},  // low bits ignored
      '{1'b0, P, 32'h0,        R,          1'b0, 32'h0,        8'd11},  // other index
      '{1'b1, S, 32'hFFFFFFF8, S,          1'b0, 32'h0,        8'd8 },  // miss
      '{1'b1, S, 32'h00000008, S,          1'b1, 32'hFFFFFFF8, 8'd2 },  // wrap learn
      '{1'b0, P, 32'h0,        S,          1'b1, 32'h00000018, 8'd10}   // wraps past 0
   };

   task automatic check(input logic ev, input logic [31:0] ea, input int rq);
      tests++;
      if (look_valid !== ev || (ev && look_addr !== ea)) begin
         fails++;
         $display("FAIL R%0d: valid=%0b addr=%h expected valid=%0b addr=%h",
                  rq, look_valid, look_addr, ev, ea);
      end
   endtask

   task automatic step(input logic ue, input logic [31:0] upc, input logic [31:0] uad,
                       input logic [31:0] lpc, input logic ev, input logic [31:0] ea,
                       input int rq);
      @(negedge clk);
      upd_en = ue; upd_pc = upc; upd_addr = uad; look_pc = lpc;
      #2;
      check(ev, ea, rq);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      for (int i = 0; i < NV; i++)
         step(VEC[i].ue, VEC[i].upc, VEC[i].uad, VEC[i].lpc, VEC[i].ev, VEC[i].ea, int'(VEC[i].rq));
      // R1: reset in mid-run empties the table
      @(negedge clk);
      upd_en = 1'b0;
      rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      step(1'b0, P, 32'h0, Q, 1'b0, 32'h0, 1);
      step(1'b0, P, 32'h0, S, 1'b0, 32'h0, 1);
      // R2 after reset: allocate then predict
      step(1'b1, S, 32'h40, S, 1'b0, 32'h0, 2);
      step(1'b0, S, 32'h0, S, 1'b1, 32'h40, 2);
      @(negedge clk) upd_en = 1'b0;
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule